// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block records which power mode a small microcontroller is in. For that mode it drives the enable and select signals for clocks, the regulator and gating. Software chooses one of three RUN sub-modes through a policy input. A sleep request carries a depth and a policy bit, and together they choose the target: a SLEEP sub-mode, STOP0, STOP2, STANDBY0, STANDBY1 or SHUTDOWN. Interrupts arrive on two vectors. One comes from the always-on peripheral domain and the other from the switchable domain. Whether an interrupt can wake the device depends on the domain it comes from and on how deep the current mode is. Only the external reset pin and debug-port activity can leave SHUTDOWN.

The block holds the mode in a register, together with the RUN sub-mode that was active when the device last went to sleep. A wake returns to that stored sub-mode. STOP0 takes its oscillator and low-power clock settings from the same stored sub-mode. All outputs are decoded from these two registers. The actual oscillators, regulators and clock multiplexers are outside this block.

Top module: `pmc_mode_ctrl`

## Requirements
- R1: A synchronous reset places the controller in RUN0 (mode code 0) with the stored RUN sub-mode set to RUN0.
- R2: Mode codes are RUN0=0, RUN1=1, RUN2=2, SLEEP0=3, SLEEP1=4, SLEEP2=5, STOP0=6, STOP2=7, STANDBY0=8, STANDBY1=9 and SHUTDOWN=10. In a RUN mode with no accepted sleep request, run policy 0, 1 or 2 selects RUN0, RUN1 or RUN2 on the next edge, and policy 3 keeps the current mode.
- R3: Clock codes are 0=off, 1=32 kHz, 2=4 MHz and 3=24 MHz. The CPU clock and the main clock are 24 MHz in RUN0 and SLEEP0 and 32 kHz in RUN1, RUN2, SLEEP1 and SLEEP2. The CPU clock is off in every SLEEP, STOP, STANDBY and SHUTDOWN mode. The main clock is off in STOP, STANDBY and SHUTDOWN.
- R4: The system oscillator enable is 1 in RUN0, RUN1, SLEEP0 and SLEEP1, and 0 in RUN2, SLEEP2, STOP2, both STANDBY modes and SHUTDOWN.
- R5: STOP0 takes its settings from the stored RUN sub-mode. From RUN0 the oscillator is on and the low-power clock is 4 MHz. From RUN1 the oscillator is on and that clock is 32 kHz. From RUN2 the oscillator is off and that clock is 32 kHz. In STOP2 that clock is 32 kHz.
- R6: In both STANDBY modes the low-power peripheral clock is off. The timer clock is 32 kHz in STANDBY1 and off in STANDBY0. In the other modes the timer clock follows the low-power clock.
- R7: In a SLEEP mode any interrupt returns the controller to the stored RUN sub-mode on the next edge. In STOP and STANDBY only an always-on-domain interrupt does this, and switchable-domain interrupts have no effect.
- R8: SHUTDOWN is left only for RUN0, on nrst_wake or dbg_wake. Interrupts have no effect in SHUTDOWN.
- R9: Regulator drive is 2 (full) in RUN and SLEEP, 1 (low) in STOP and STANDBY, and 0 (off) in SHUTDOWN.
- R10: Flash and SRAM are enabled in RUN. In SLEEP and STOP they follow mem_keep. They are gated in STANDBY and SHUTDOWN. The switchable-domain enable is 1 only in RUN and SLEEP. trig_only is 1 only in STOP and STANDBY.
- R11: A sleep request is ignored while a wake-eligible interrupt is pending. For depth SLEEP that is any interrupt. For depth STOP or STANDBY it is an always-on-domain interrupt. Interrupts never block a SHUTDOWN request.
- R12: Sleep depth codes are 0=SLEEP, 1=STOP, 2=STANDBY and 3=SHUTDOWN. Depth SLEEP enters the SLEEP sub-mode with the same index as the current RUN sub-mode. A policy bit of 0 or 1 selects STOP0 or STOP2, and STANDBY0 or STANDBY1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_pol | input | 2 | Requested RUN sub-mode (3 = hold) |
| sleep_req | input | 1 | Request to enter a low-power mode |
| sleep_depth | input | 2 | Target depth of the sleep request |
| sleep_pol | input | 1 | Policy bit selecting the STOP or STANDBY variant |
| irq_pd0 | input | N_PD0_IRQ | Interrupts from the always-on domain |
| irq_pd1 | input | N_PD1_IRQ | Interrupts from the switchable domain |
| nrst_wake | input | 1 | External reset pin activity |
| dbg_wake | input | 1 | Debug-port activity |
| mem_keep | input | 1 | Keep flash and SRAM enabled in SLEEP and STOP |
| mode_o | output | 4 | Current mode code |
| sysosc_en | output | 1 | System oscillator enable |
| cpuclk_sel | output | 2 | CPU clock code |
| mclk_sel | output | 2 | Main clock code |
| ulpclk_sel | output | 2 | Low-power peripheral clock code |
| timclk_sel | output | 2 | Timer clock code |
| reg_drive | output | 2 | Regulator drive level |
| flash_en | output | 1 | Flash enable |
| sram_en | output | 1 | SRAM enable |
| pd1_en | output | 1 | Switchable-domain enable |
| trig_only | output | 1 | DMA and ADC restricted to trigger support |

## Verification
On every cycle the assertions check the following: the CPU clock is gated in SLEEP, the regulator is off in SHUTDOWN, and memories are gated in STANDBY. They also check that SHUTDOWN holds without reset-pin or debug activity, that a deep mode returns to the stored RUN sub-mode on an always-on interrupt and holds without one, and that a pending interrupt blocks a SLEEP request. Some behaviour can only be shown by the bench's scenarios, because it depends on the path that led to a state. This covers STOP0 taking its settings from each RUN sub-mode, wakes returning to RUN1 or RUN2 after a long sleep, and the policy and depth encodings. The bench's reference model covers these under random traffic and in directed sequences.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [3:0] {
        M_RUN0   = 4'd0,
        M_RUN1   = 4'd1,
        M_RUN2   = 4'd2,
        M_SLP0   = 4'd3,
        M_SLP1   = 4'd4,
        M_SLP2   = 4'd5,
        M_STOP0  = 4'd6,
        M_STOP2  = 4'd7,
        M_STBY0  = 4'd8,
        M_STBY1  = 4'd9,
        M_SHDN   = 4'd10
    } pm_mode_e;

    typedef enum logic [1:0] {
        DEP_SLEEP = 2'd0,
        DEP_STOP  = 2'd1,
        DEP_STBY  = 2'd2,
        DEP_SHDN  = 2'd3
    } pm_depth_e;

    localparam logic [1:0] CK_OFF = 2'd0;
    localparam logic [1:0] CK_32K = 2'd1;
    localparam logic [1:0] CK_4M  = 2'd2;
    localparam logic [1:0] CK_24M = 2'd3;

    localparam logic [1:0] DRV_OFF  = 2'd0;
    localparam logic [1:0] DRV_LOW  = 2'd1;
    localparam logic [1:0] DRV_FULL = 2'd2;

    typedef struct packed {
        logic       sysosc_en;
        logic [1:0] cpu_sel;
        logic [1:0] mclk_sel;
        logic [1:0] ulp_sel;
        logic [1:0] tim_sel;
        logic [1:0] drive;
        logic       flash_en;
        logic       sram_en;
        logic       pd1_en;
        logic       trig_only;
    } pm_ctrl_t;

    function automatic logic is_run(input pm_mode_e m);
        return (m == M_RUN0) || (m == M_RUN1) || (m == M_RUN2);
    endfunction

    function automatic logic is_sleep(input pm_mode_e m);
        return (m == M_SLP0) || (m == M_SLP1) || (m == M_SLP2);
    endfunction

    function automatic logic is_deep(input pm_mode_e m);
        return (m == M_STOP0) || (m == M_STOP2) || (m == M_STBY0) || (m == M_STBY1);
    endfunction

    function automatic logic [1:0] run_clk(input pm_mode_e r);
        return (r == M_RUN0) ? CK_24M : CK_32K;
    endfunction

endpackage

// File: rtl/pmc_next.sv
module pmc_next
    import pmc_pkg::*;
#(
    parameter int N_PD0_IRQ = 4,
    parameter int N_PD1_IRQ = 2
) (
    input  pm_mode_e               mode_q,
    input  pm_mode_e               last_run_q,
    input  logic [1:0]             run_pol,
    input  logic                   sleep_req,
    input  logic [1:0]             sleep_depth,
    input  logic                   sleep_pol,
    input  logic [N_PD0_IRQ-1:0]   irq_pd0,
    input  logic [N_PD1_IRQ-1:0]   irq_pd1,
    input  logic                   nrst_wake,
    input  logic                   dbg_wake,
    output pm_mode_e               mode_d
);

    logic      aon_irq;
    logic      any_irq;
    logic      blocked;
    pm_mode_e  target;
    pm_mode_e  run_sel;
    pm_depth_e depth;

    assign depth   = pm_depth_e'(sleep_depth);
    assign aon_irq = |irq_pd0;
    assign any_irq = aon_irq | (|irq_pd1);

    always_comb begin
        unique case (depth)
            DEP_SLEEP: blocked = any_irq;
            DEP_SHDN:  blocked = 1'b0;
            default:   blocked = aon_irq;
        endcase
    end

    always_comb begin
        unique case (depth)
            DEP_SLEEP: begin
                unique case (mode_q)
                    M_RUN1:  target = M_SLP1;
                    M_RUN2:  target = M_SLP2;
                    default: target = M_SLP0;
                endcase
            end
            DEP_STOP: target = sleep_pol ? M_STOP2 : M_STOP0;
            DEP_STBY: target = sleep_pol ? M_STBY1 : M_STBY0;
            default:  target = M_SHDN;
        endcase
    end

    always_comb begin
        unique case (run_pol)
            2'd0:    run_sel = M_RUN0;
            2'd1:    run_sel = M_RUN1;
            2'd2:    run_sel = M_RUN2;
            default: run_sel = mode_q;
        endcase
    end

    always_comb begin
        mode_d = mode_q;
        if (is_run(mode_q)) begin
            if (sleep_req && !blocked) begin
                mode_d = target;
            end else begin
                mode_d = run_sel;
            end
        end else if (is_sleep(mode_q)) begin
            if (any_irq) begin
                mode_d = last_run_q;
            end
        end else if (is_deep(mode_q)) begin
            if (aon_irq) begin
                mode_d = last_run_q;
            end
        end else if (mode_q == M_SHDN) begin
            if (nrst_wake || dbg_wake) begin
                mode_d = M_RUN0;
            end
        end else begin
            mode_d = M_RUN0;
        end
    end

endmodule

// File: rtl/pmc_out_dec.sv
module pmc_out_dec
    import pmc_pkg::*;
(
    input  pm_mode_e mode_q,
    input  pm_mode_e last_run_q,
    input  logic     mem_keep,
    output pm_ctrl_t ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (mode_q)
            M_RUN0, M_RUN1, M_RUN2: begin
                ctrl.sysosc_en = (mode_q != M_RUN2);
                ctrl.cpu_sel   = run_clk(mode_q);
                ctrl.mclk_sel  = run_clk(mode_q);
                ctrl.ulp_sel   = run_clk(mode_q);
                ctrl.tim_sel   = run_clk(mode_q);
                ctrl.drive     = DRV_FULL;
                ctrl.flash_en  = 1'b1;
                ctrl.sram_en   = 1'b1;
                ctrl.pd1_en    = 1'b1;
            end
            M_SLP0, M_SLP1, M_SLP2: begin
                ctrl.sysosc_en = (mode_q != M_SLP2);
                ctrl.cpu_sel   = CK_OFF;
                ctrl.mclk_sel  = (mode_q == M_SLP0) ? CK_24M : CK_32K;
                ctrl.ulp_sel   = ctrl.mclk_sel;
                ctrl.tim_sel   = ctrl.mclk_sel;
                ctrl.drive     = DRV_FULL;
                ctrl.flash_en  = mem_keep;
                ctrl.sram_en   = mem_keep;
                ctrl.pd1_en    = 1'b1;
            end
            M_STOP0: begin
                ctrl.sysosc_en = (last_run_q != M_RUN2);
                ctrl.ulp_sel   = (last_run_q == M_RUN0) ? CK_4M : CK_32K;
                ctrl.tim_sel   = ctrl.ulp_sel;
                ctrl.drive     = DRV_LOW;
                ctrl.flash_en  = mem_keep;
                ctrl.sram_en   = mem_keep;
                ctrl.trig_only = 1'b1;
            end
            M_STOP2: begin
                ctrl.ulp_sel   = CK_32K;
                ctrl.tim_sel   = CK_32K;
                ctrl.drive     = DRV_LOW;
                ctrl.flash_en  = mem_keep;
                ctrl.sram_en   = mem_keep;
                ctrl.trig_only = 1'b1;
            end
            M_STBY0, M_STBY1: begin
                ctrl.tim_sel   = (mode_q == M_STBY1) ? CK_32K : CK_OFF;
                ctrl.drive     = DRV_LOW;
                ctrl.trig_only = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int N_PD0_IRQ = 4,
    parameter int N_PD1_IRQ = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           run_pol,
    input  logic                 sleep_req,
    input  logic [1:0]           sleep_depth,
    input  logic                 sleep_pol,
    input  logic [N_PD0_IRQ-1:0] irq_pd0,
    input  logic [N_PD1_IRQ-1:0] irq_pd1,
    input  logic                 nrst_wake,
    input  logic                 dbg_wake,
    input  logic                 mem_keep,
    output logic [3:0]           mode_o,
    output logic                 sysosc_en,
    output logic [1:0]           cpuclk_sel,
    output logic [1:0]           mclk_sel,
    output logic [1:0]           ulpclk_sel,
    output logic [1:0]           timclk_sel,
    output logic [1:0]           reg_drive,
    output logic                 flash_en,
    output logic                 sram_en,
    output logic                 pd1_en,
    output logic                 trig_only
);

    pm_mode_e mode_q, mode_d;
    pm_mode_e last_run_q, last_run_d;
    pm_ctrl_t ctrl;

    pmc_next #(
        .N_PD0_IRQ (N_PD0_IRQ),
        .N_PD1_IRQ (N_PD1_IRQ)
    ) next_i (
        .mode_q      (mode_q),
        .last_run_q  (last_run_q),
        .run_pol     (run_pol),
        .sleep_req   (sleep_req),
        .sleep_depth (sleep_depth),
        .sleep_pol   (sleep_pol),
        .irq_pd0     (irq_pd0),
        .irq_pd1     (irq_pd1),
        .nrst_wake   (nrst_wake),
        .dbg_wake    (dbg_wake),
        .mode_d      (mode_d)
    );

    always_comb begin
        if (is_run(mode_d)) begin
            last_run_d = mode_d;
        end else if (mode_d == M_SHDN) begin
            last_run_d = M_RUN0;
        end else begin
            last_run_d = last_run_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= M_RUN0;
            last_run_q <= M_RUN0;
        end else begin
            mode_q     <= mode_d;
            last_run_q <= last_run_d;
        end
    end

    pmc_out_dec dec_i (
        .mode_q     (mode_q),
        .last_run_q (last_run_q),
        .mem_keep   (mem_keep),
        .ctrl       (ctrl)
    );

    assign mode_o     = mode_q;
    assign sysosc_en  = ctrl.sysosc_en;
    assign cpuclk_sel = ctrl.cpu_sel;
    assign mclk_sel   = ctrl.mclk_sel;
    assign ulpclk_sel = ctrl.ulp_sel;
    assign timclk_sel = ctrl.tim_sel;
    assign reg_drive  = ctrl.drive;
    assign flash_en   = ctrl.flash_en;
    assign sram_en    = ctrl.sram_en;
    assign pd1_en     = ctrl.pd1_en;
    assign trig_only  = ctrl.trig_only;

endmodule

// File: rtl/pmc_mode_ctrl_chk.sv
module pmc_mode_ctrl_chk #(
    parameter int N_PD0_IRQ = 4,
    parameter int N_PD1_IRQ = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [3:0]           mode_o,
    input logic [3:0]           last_run_q,
    input logic                 sleep_req,
    input logic [1:0]           sleep_depth,
    input logic [N_PD0_IRQ-1:0] irq_pd0,
    input logic [N_PD1_IRQ-1:0] irq_pd1,
    input logic                 nrst_wake,
    input logic                 dbg_wake,
    input logic [1:0]           cpuclk_sel,
    input logic [1:0]           reg_drive,
    input logic                 flash_en,
    input logic                 sram_en
);

    logic in_run, in_sleep, in_deep;
    assign in_run   = (mode_o <= 4'd2);
    assign in_sleep = (mode_o >= 4'd3) && (mode_o <= 4'd5);
    assign in_deep  = (mode_o >= 4'd6) && (mode_o <= 4'd9);

    AST_RESET_RUN0: assert property (@(posedge clk)
        rst |=> (mode_o == 4'd0));                                                  // R1

    AST_SLEEP_CPU_GATED: assert property (@(posedge clk) disable iff (rst)
        in_sleep |-> (cpuclk_sel == 2'd0));                                         // R3

    AST_SHDN_REG_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 4'd10) |-> (reg_drive == 2'd0));                                 // R9

    AST_STBY_MEM_GATED: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == 4'd8) || (mode_o == 4'd9)) |-> (!flash_en && !sram_en));       // R10

    AST_SHDN_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == 4'd10) && !nrst_wake && !dbg_wake) |=> (mode_o == 4'd10));     // R8

    AST_DEEP_WAKE_RETURN: assert property (@(posedge clk) disable iff (rst)
        (in_deep && (|irq_pd0)) |=> (mode_o == $past(last_run_q)));                 // R7

    AST_DEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_deep && !(|irq_pd0)) |=> (mode_o == $past(mode_o)));                    // R7

    AST_SLEEP_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (in_run && sleep_req && (sleep_depth == 2'd0) && ((|irq_pd0) || (|irq_pd1)))
        |=> (mode_o <= 4'd2));                                                      // R11

endmodule

bind pmc_mode_ctrl pmc_mode_ctrl_chk #(
    .N_PD0_IRQ (N_PD0_IRQ),
    .N_PD1_IRQ (N_PD1_IRQ)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .mode_o      (mode_o),
    .last_run_q  (last_run_q),
    .sleep_req   (sleep_req),
    .sleep_depth (sleep_depth),
    .irq_pd0     (irq_pd0),
    .irq_pd1     (irq_pd1),
    .nrst_wake   (nrst_wake),
    .dbg_wake    (dbg_wake),
    .cpuclk_sel  (cpuclk_sel),
    .reg_drive   (reg_drive),
    .flash_en    (flash_en),
    .sram_en     (sram_en)
);

// File: tb/pmc_mode_ctrl_tb_top.sv
module pmc_mode_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] run_pol = 2'd3;
    logic       sleep_req = 1'b0;
    logic [1:0] sleep_depth = 2'd0;
    logic       sleep_pol = 1'b0;
    logic [3:0] irq_pd0 = '0;
    logic [1:0] irq_pd1 = '0;
    logic       nrst_wake = 1'b0;
    logic       dbg_wake = 1'b0;
    logic       mem_keep = 1'b0;

    logic [3:0] mode_o;
    logic       sysosc_en;
    logic [1:0] cpuclk_sel, mclk_sel, ulpclk_sel, timclk_sel, reg_drive;
    logic       flash_en, sram_en, pd1_en, trig_only;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int m_mode = 0;
    int m_lr   = 0;

    always #2 clk = ~clk;

    pmc_mode_ctrl dut_i (
        .clk(clk), .rst(rst), .run_pol(run_pol), .sleep_req(sleep_req),
        .sleep_depth(sleep_depth), .sleep_pol(sleep_pol), .irq_pd0(irq_pd0),
        .irq_pd1(irq_pd1), .nrst_wake(nrst_wake), .dbg_wake(dbg_wake),
        .mem_keep(mem_keep), .mode_o(mode_o), .sysosc_en(sysosc_en),
        .cpuclk_sel(cpuclk_sel), .mclk_sel(mclk_sel), .ulpclk_sel(ulpclk_sel),
        .timclk_sel(timclk_sel), .reg_drive(reg_drive), .flash_en(flash_en),
        .sram_en(sram_en), .pd1_en(pd1_en), .trig_only(trig_only)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int mdl_next(input int m, input int lr, input int rp, input bit sr,
                                    input int dp, input bit pl, input bit p0, input bit p1,
                                    input bit nw, input bit dw);
        bit blk;
        if (m <= 2) begin
            blk = (dp == 0) ? (p0 || p1) : (dp == 3) ? 1'b0 : p0;
            if (sr && !blk) begin
                if (dp == 0) return m + 3;
                if (dp == 1) return pl ? 7 : 6;
                if (dp == 2) return pl ? 9 : 8;
                return 10;
            end
            return (rp == 3) ? m : rp;
        end
        if (m <= 5) return (p0 || p1) ? lr : m;
        if (m <= 9) return p0 ? lr : m;
        return (nw || dw) ? 0 : 10;
    endfunction

    task automatic compare_all();
        int ck, osc, ulp, tim, drv, mem, p1e, trg;
        ck  = (m_mode == 0 || m_mode == 3) ? 3 : (m_mode <= 5) ? 1 : 0;
        osc = (m_mode == 0 || m_mode == 1 || m_mode == 3 || m_mode == 4) ? 1 :
              (m_mode == 6 && m_lr != 2) ? 1 : 0;
        ulp = (m_mode <= 5) ? ck : (m_mode == 6) ? ((m_lr == 0) ? 2 : 1) : (m_mode == 7) ? 1 : 0;
        tim = (m_mode == 9) ? 1 : ulp;
        drv = (m_mode <= 5) ? 2 : (m_mode <= 9) ? 1 : 0;
        mem = (m_mode <= 2) ? 1 : (m_mode <= 7) ? int'(mem_keep) : 0;
        p1e = (m_mode <= 5) ? 1 : 0;
        trg = (m_mode >= 6 && m_mode <= 9) ? 1 : 0;
        check("R2/R7/R8/R11/R12 mode", int'(mode_o), m_mode);
        check("R3 cpu clock", int'(cpuclk_sel), (m_mode <= 2) ? ck : 0);
        check("R3 main clock", int'(mclk_sel), ck);
        check("R4 oscillator", int'(sysosc_en), osc);
        check("R5 low-power clock", int'(ulpclk_sel), ulp);
        check("R6 timer clock", int'(timclk_sel), tim);
        check("R9 regulator", int'(reg_drive), drv);
        check("R10 flash", int'(flash_en), mem);
        check("R10 sram", int'(sram_en), mem);
        check("R10 pd1 enable", int'(pd1_en), p1e);
        check("R10 trigger only", int'(trig_only), trg);
    endtask

    task automatic step(input int rp, input bit sr, input int dp, input bit pl,
                        input logic [3:0] i0, input logic [1:0] i1,
                        input bit nw, input bit dw, input bit mk);
        run_pol = 2'(rp); sleep_req = sr; sleep_depth = 2'(dp); sleep_pol = pl;
        irq_pd0 = i0; irq_pd1 = i1; nrst_wake = nw; dbg_wake = dw; mem_keep = mk;
        @(posedge clk);
        if (rst) begin
            m_mode = 0; m_lr = 0;
        end else begin
            m_mode = mdl_next(m_mode, m_lr, rp, sr, dp, pl, |i0, |i1, nw, dw);
            if (m_mode <= 2) m_lr = m_mode;
            else if (m_mode == 10) m_lr = 0;
        end
        @(negedge clk);
        cyc++;
        compare_all();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(3, 0, 0, 0, '0, '0, 0, 0, 0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        @(negedge clk);
        do_reset();
        check("R1 reset mode", int'(mode_o), 0);
        check("R1 reset oscillator", int'(sysosc_en), 1);
        check("R1 reset cpu clock", int'(cpuclk_sel), 3);

        // R5: STOP0 entered from each RUN sub-mode
        for (int r = 0; r < 3; r++) begin
            step(r, 0, 0, 0, '0, '0, 0, 0, 1);
            step(3, 1, 1, 0, '0, '0, 0, 0, 1);
            check("R5 stop0 entered", int'(mode_o), 6);
            check("R5 stop0 low-power clock", int'(ulpclk_sel), (r == 0) ? 2 : 1);
            check("R5 stop0 oscillator", int'(sysosc_en), (r == 2) ? 0 : 1);
            step(0, 0, 0, 0, '0, 2'b11, 0, 0, 1);
            check("R7 pd1 irq ignored in stop", int'(mode_o), 6);
            step(0, 0, 0, 0, 4'b0100, '0, 0, 0, 1);
            check("R7 wake returns to run", int'(mode_o), r);
        end

        // R11: blocked sleep requests, and R12 standby1 entry
        step(1, 0, 0, 0, '0, '0, 0, 0, 0);
        step(3, 1, 0, 0, '0, 2'b01, 0, 0, 0);
        check("R11 sleep blocked by pd1", int'(mode_o), 1);
        step(3, 1, 2, 1, 4'b0001, '0, 0, 0, 0);
        check("R11 standby blocked by pd0", int'(mode_o), 1);
        step(3, 1, 2, 1, '0, 2'b10, 0, 0, 0);
        check("R12 standby1 entered", int'(mode_o), 9);
        check("R6 standby1 timer clock", int'(timclk_sel), 1);

        // R8: shutdown ignores irqs, exits on debug
        step(3, 0, 0, 0, 4'b0010, '0, 0, 0, 0);
        step(2, 1, 3, 0, 4'b1111, 2'b11, 0, 0, 0);
        check("R8 shutdown despite irq", int'(mode_o), 10);
        step(0, 1, 0, 0, 4'b1111, 2'b11, 0, 0, 0);
        check("R8 irq ignored in shutdown", int'(mode_o), 10);
        step(1, 0, 0, 0, '0, '0, 0, 1, 0);
        check("R8 debug wake to run0", int'(mode_o), 0);
        step(3, 1, 0, 0, '0, '0, 0, 0, 0);
        check("R12 sleep0 entered", int'(mode_o), 3);

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int rp, dp;
            bit sr, pl, nw, dw, mk;
            logic [3:0] i0;
            logic [1:0] i1;
            rp = int'($urandom_range(0, 3));
            dp = int'($urandom_range(0, 3));
            if (dp == 3 && $urandom_range(0, 3) != 0) dp = 1;
            sr = ($urandom_range(0, 3) == 0);
            pl = 1'($urandom_range(0, 1));
            mk = 1'($urandom_range(0, 1));
            i0 = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
            i1 = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            nw = ($urandom_range(0, 15) == 0);
            dw = ($urandom_range(0, 15) == 0);
            if (i % 997 == 500) begin
                rst = 1'b1;
                step(rp, sr, dp, pl, i0, i1, nw, dw, mk);
                check("R1 reset mid-run", int'(mode_o), 0);
                rst = 1'b0;
            end else begin
                step(rp, sr, dp, pl, i0, i1, nw, dw, mk);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule